// File: doc/BRIEF.md
# I2C Bus Occupancy Watcher

This block listens passively to the clock and data wires of a shared two-wire bus. It recognises the two framing events of the protocol: data falling while the clock is high (a start) and data rising while the clock is high (a stop). From these events it keeps two sticky status flags. A busy flag is set by a start. A released flag is set by a stop. Each event clears the other flag.

A master that wants to take the bus reads `bus_free`. The bus counts as free when the released flag is set, or when neither flag is set because no framing event has been seen since the block was enabled. The block can also raise a one-cycle interrupt when a stop ends a transfer that was seen in progress. Software that found the bus busy can then wait for that event instead of polling.

Both wires pass through a configurable flop synchroniser before edge detection, so asynchronous bus activity enters the system clock domain safely. The block never drives the bus.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset, `s_flag` and `p_flag` are 0, `bus_free` is 1 and `irq_pulse` is 0.
- R2: While `enable` is low, both flags are held at 0 on the next clock edge. Start and stop events seen while disabled leave no trace once the block is enabled again.
- R3: A start is a synchronised SDA transition from 1 to 0 while synchronised SCL is 1 in both the current and the previous sample. When enabled, a start sets `s_flag` to 1 and `p_flag` to 0.
- R4: A stop is a synchronised SDA transition from 0 to 1 while synchronised SCL is 1 in both samples. When enabled, a stop sets `p_flag` to 1 and `s_flag` to 0.
- R5: `bus_free` is 1 exactly when `p_flag` is 1 or when both flags are 0. It is 0 while `s_flag` is 1.
- R6: When a stop is detected while `s_flag` is 1, `irq_en` is 1 and `enable` is 1, `irq_pulse` is 1 for exactly one clock cycle. That cycle is the one in which `p_flag` first reads 1.
- R7: A stop detected while `s_flag` is 0, or while `irq_en` is 0, raises no interrupt.
- R8: SDA changes while SCL is low change no flag. An SCL and SDA change that is synchronised in the same cycle is not a condition.
- R9: With `SYNC_STAGES` = 2, a flag changes on the third rising clock edge after the bus input changes, and not earlier.
- R10: A repeated start, seen while `s_flag` is already 1, keeps `s_flag` at 1 and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears both flags |
| irq_en | input | 1 | Allows the stop-while-busy interrupt |
| scl_in | input | 1 | Raw bus clock wire level |
| sda_in | input | 1 | Raw bus data wire level |
| s_flag | output | 1 | Sticky: last framing event was a start |
| p_flag | output | 1 | Sticky: last framing event was a stop |
| bus_free | output | 1 | Bus may be claimed |
| irq_pulse | output | 1 | One-cycle interrupt on a stop that ends a busy period |

## Verification
The case hardest to reach from the ports is the difference between a stop that ends a busy period and a stop that arrives while the block already reads idle. Only the first may raise the interrupt. To reach both, the stimulus completes a full start, data, stop transfer. It then forms a second stop without an intervening start, by lowering SCL, lowering SDA, raising SCL and then raising SDA. A third variant disables the block mid-transfer and re-enables it with the bus busy, so that the next stop again finds both flags clear. The bench queues an expected interrupt only for the first case. Any pulse with an empty queue is reported.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

    // index of each bus wire inside the synchroniser bundle
    localparam int unsigned LINE_SCL = 0;
    localparam int unsigned LINE_SDA = 1;
    localparam int unsigned LINE_CNT = 2;

    // sampled level pair used by the edge detector
    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

    // framing event decoded in one cycle
    typedef struct packed {
        logic start;
        logic stop;
    } cond_t;

    // registered flag state of the status tracker
    typedef struct packed {
        logic s;
        logic p;
        logic irq;
    } flag_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o
);
    // a single stage gives no metastability margin, so two is the floor
    localparam int unsigned STG = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [LINES-1:0][STG-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < LINES; i++) begin
            st_d.chain[i] = {st_q.chain[i][STG-2:0], raw_i[i]};
        end
    end

    // idle bus wires are pulled high, so reset to ones to avoid a false edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_out
            assign sync_o[g] = st_q.chain[g][STG-1];
        end
    endgenerate

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_watch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        line_pair_t prev;
    } det_state_t;

    det_state_t st_d, st_q;
    cond_t      cond;
    logic       scl_held;

    always_comb begin
        st_d          = st_q;
        st_d.prev.scl = scl_i;
        st_d.prev.sda = sda_i;

        // clock must be high before and after the data edge
        scl_held   = st_q.prev.scl & scl_i;
        cond.start = scl_held &  st_q.prev.sda & ~sda_i;
        cond.stop  = scl_held & ~st_q.prev.sda &  sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = cond.start;
    assign stop_o  = cond.stop;

endmodule

// File: rtl/i2c_bus_status.sv
module i2c_bus_status
    import i2c_watch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic irq_en_i,
    input  logic start_i,
    input  logic stop_i,
    output logic s_o,
    output logic p_o,
    output logic free_o,
    output logic irq_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!enable_i) begin
            st_d.s = 1'b0;
            st_d.p = 1'b0;
        end else if (start_i) begin
            st_d.s = 1'b1;
            st_d.p = 1'b0;
        end else if (stop_i) begin
            // only a stop that closes an observed transfer interrupts
            st_d.irq = irq_en_i & st_q.s;
            st_d.s   = 1'b0;
            st_d.p   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s_o    = st_q.s;
    assign p_o    = st_q.p;
    assign free_o = st_q.p | (~st_q.s & ~st_q.p);
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2c_watch_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic irq_en,
    input  logic scl_in,
    input  logic sda_in,
    output logic s_flag,
    output logic p_flag,
    output logic bus_free,
    output logic irq_pulse
);
    logic [LINE_CNT-1:0] raw_lines;
    logic [LINE_CNT-1:0] sync_lines;
    logic                start_det;
    logic                stop_det;

    always_comb begin
        raw_lines           = '0;
        raw_lines[LINE_SCL] = scl_in;
        raw_lines[LINE_SDA] = sda_in;
    end

    i2c_line_sync #(
        .LINES  (LINE_CNT),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_lines),
        .sync_o (sync_lines)
    );

    i2c_cond_detect det_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (sync_lines[LINE_SCL]),
        .sda_i   (sync_lines[LINE_SDA]),
        .start_o (start_det),
        .stop_o  (stop_det)
    );

    i2c_bus_status stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable),
        .irq_en_i (irq_en),
        .start_i  (start_det),
        .stop_i   (stop_det),
        .s_o      (s_flag),
        .p_o      (p_flag),
        .free_o   (bus_free),
        .irq_o    (irq_pulse)
    );

endmodule

// File: rtl/i2c_bus_watch_chk.sv
module i2c_bus_watch_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic irq_en,
    input logic s_flag,
    input logic p_flag,
    input logic bus_free,
    input logic irq_pulse,
    input logic start_det,
    input logic stop_det
);
    p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!s_flag && !p_flag));

    p_start_sets_s_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_det) |=> (s_flag && !p_flag));

    p_stop_sets_p_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && stop_det) |=> (p_flag && !s_flag));

    p_busy_not_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_flag |-> !bus_free);

    p_released_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        p_flag |-> bus_free);

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (p_flag && $past(s_flag) && $past(irq_en) && $past(stop_det)));

    p_no_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !s_flag) |=> !irq_pulse);

    p_no_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !irq_en) |=> !irq_pulse);

    p_restart_keeps_s_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_det && s_flag) |=> (s_flag && !irq_pulse));

endmodule

bind i2c_bus_watch i2c_bus_watch_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .irq_en    (irq_en),
    .s_flag    (s_flag),
    .p_flag    (p_flag),
    .bus_free  (bus_free),
    .irq_pulse (irq_pulse),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/i2c_bus_watch_tb_top.sv
`timescale 1ns/1ps
module i2c_bus_watch_tb_top;

    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic irq_en = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic s_flag, p_flag, bus_free, irq_pulse;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int irq_id = 0;
    logic prev_irq = 1'b0;

    always #2.5 clk = ~clk;

    i2c_bus_watch dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .irq_en    (irq_en),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .s_flag    (s_flag),
        .p_flag    (p_flag),
        .bus_free  (bus_free),
        .irq_pulse (irq_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input int s, input int p, input int fr);
        chk({req, " s_flag"}, int'(s_flag), s);
        chk({req, " p_flag"}, int'(p_flag), p);
        chk({req, " bus_free"}, int'(bus_free), fr);
    endtask

    task automatic drive(input logic scl, input logic sda);
        @(negedge clk);
        scl_in = scl;
        sda_in = sda;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic do_start();
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
    endtask

    // stop formed from any line state; pushes an expected irq when asked
    task automatic do_stop(input bit expect_irq);
        drive(1'b0, sda_in);
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        if (expect_irq) begin
            irq_id++;
            exp_q.push_back(irq_id);
        end
        drive(1'b1, 1'b1);
    endtask

    task automatic data_bit(input logic b);
        drive(1'b0, sda_in);
        drive(1'b0, b);
        drive(1'b1, b);
        drive(1'b0, b);
    endtask

    // monitor: every interrupt pulse must match a queued expectation (R6, R7)
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_pulse) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R7 unexpected irq actual=1 expected=0");
                end else begin
                    void'(exp_q.pop_front());
                    chk("R6 p_flag at irq", int'(p_flag), 1);
                    chk("R6 s_flag at irq", int'(s_flag), 0);
                end
                chk("R6 pulse width", int'(prev_irq), 0);
            end
            prev_irq = irq_pulse;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_flags("R1 reset", 0, 0, 1);
        chk("R1 irq", int'(irq_pulse), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        irq_en = 1'b1;
        repeat (2) @(negedge clk);
        chk_flags("R1 idle after enable", 0, 0, 1);

        // R9 latency of a start
        drive(1'b1, 1'b1);
        sda_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 s before third edge", int'(s_flag), 0);
        @(negedge clk);
        chk("R9 s after third edge", int'(s_flag), 1);
        repeat (HOLD) @(negedge clk);
        chk_flags("R3 start", 1, 0, 0);

        // data bits: SDA moves only while SCL low
        data_bit(1'b1);
        data_bit(1'b0);
        data_bit(1'b1);
        chk_flags("R8 data bits", 1, 0, 0);

        // R10 repeated start while busy
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
        chk_flags("R10 repeated start", 1, 0, 0);

        // stop ending a busy period with interrupt
        do_stop(1'b1);
        chk_flags("R4 stop", 0, 1, 1);
        chk("R6 irq consumed", exp_q.size(), 0);

        // stop while already released: no interrupt
        do_stop(1'b0);
        chk_flags("R7 idle stop", 0, 1, 1);

        // masked interrupt
        irq_en = 1'b0;
        do_start();
        chk_flags("R3 second start", 1, 0, 0);
        do_stop(1'b0);
        chk_flags("R7 masked stop", 0, 1, 1);
        irq_en = 1'b1;

        // R8 simultaneous SCL and SDA change is no condition
        drive(1'b0, 1'b0);
        @(negedge clk);
        scl_in = 1'b1;
        sda_in = 1'b1;
        repeat (HOLD) @(negedge clk);
        chk_flags("R8 simultaneous rise", 0, 1, 1);
        @(negedge clk);
        scl_in = 1'b0;
        sda_in = 1'b0;
        repeat (HOLD) @(negedge clk);
        chk_flags("R8 simultaneous fall", 0, 1, 1);
        drive(1'b1, 1'b1);

        // R2 disable mid-transfer
        do_start();
        chk_flags("R3 third start", 1, 0, 0);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        chk_flags("R2 disabled", 0, 0, 1);
        data_bit(1'b0);
        do_stop(1'b0);
        do_start();
        chk_flags("R2 events ignored while disabled", 0, 0, 1);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        chk_flags("R2 re-enabled idle", 0, 0, 1);
        do_stop(1'b0);
        chk_flags("R7 stop after re-enable", 0, 1, 1);

        // R5 full cycle once more with interrupt
        do_start();
        chk("R5 busy not free", int'(bus_free), 0);
        do_stop(1'b1);
        chk("R5 released free", int'(bus_free), 1);

        repeat (4) @(negedge clk);
        chk("R6 all irqs seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule